// File: doc/BRIEF.md
# Multi-mode address modifier unit

This unit works out, for one memory access per cycle, the effective address and the new value of a 32-bit address pointer. The caller supplies the pointer's current value, an offset, an index, a displacement or immediate, a base value and a modifier value. It also supplies an operation code, an access width and the number of the pointer in use. The pointer number selects a 2-bit arithmetic mode from a packed mode-control word.

Four kinds of pointer arithmetic are available: plain linear, single-wrap circular buffering between a base and a length, power-of-two wrap that changes only the low bits, and reverse-carry update for bit-reversed access. Steps, offsets and short displacements are scaled by the access width. Both results are registered together with a valid flag. Storage of the pointers, decoding of instructions and the memory side are the caller's job.

Top module: `addr_mod_unit`

## Requirements
- R1: Width code `width` 0/1/2/3 means 1/2/4/8-byte access. Operation code 0 (post-increment) and code 1 (post-decrement) return the pointer as the effective address and step the pointer by that many bytes.
- R2: Code 2 post-adds the offset shifted left by `width`. Code 7 post-adds the displacement with no scaling. Both return the pointer as the effective address, and both follow the selected mode exactly as codes 0 and 1 do.
- R3: Code 3 gives pointer + (offset << width) and code 4 gives pointer + (index << width). Code 5 gives pointer + (displacement << width) and code 6 gives pointer + displacement with no scaling. In all four cases the updated pointer equals the input pointer.
- R4: Mode 2'b11 (reverse-carry) adds or subtracts the scaled step with the carry running from bit 31 down toward bit 0. From 0xC00 with a step of 0x800, three updates give 0x200, 0xA00 and 0x600.
- R5: Mode 2'b01 (circular) keeps the buffer [base, base+modv). An upward step whose result reaches base+modv has modv subtracted from it. For example, base 0x1007 with length 0xA0 takes a byte increment from 0x10A6 to 0x1007.
- R6: In mode 2'b01, a downward step that lands below base has modv added to it. From 0x1007 a byte decrement gives 0x10A6. Steps larger than modv are not supported.
- R7: Mode 2'b10 (power-of-two wrap) treats modv as a mask of the form 2^k-1. Only the bits under the mask change, and they wrap as many times as needed. Pointer 0xABC4 with mask 7 and a 16-bit step of offset 0x11 gives 0xABC6, then 0xABC0. An unscaled add of 0x12 after that gives 0xABC2.
- R8: Code 8 (push) gives the pointer as the address and pointer+8. Code 9 (pop) gives pointer-8 as both the address and the new pointer. Both ignore `width` and the mode.
- R9: For the pointer numbered i below 8, the mode is mode_ctl[2i+1:2i]. Pointers 8 to 15 always use linear arithmetic (mode 2'b00), whatever mode_ctl holds.
- R10: Outputs are registered. out_valid in a cycle equals req_valid of the previous cycle. ea and next_ptr keep their values while req_valid is low. All three outputs are 0 after reset.
- R11: Operation codes 10 to 15 return the pointer unchanged as both the address and the updated pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| op | input | 4 | Operation code (R1, R2, R3, R8, R11) |
| ptr_sel | input | 4 | Number of the pointer in use, selects the mode |
| mode_ctl | input | 16 | Two mode bits for each of pointers 0 to 7 |
| width | input | 2 | Access width code |
| ptr | input | 32 | Current pointer value |
| ofs | input | 32 | Offset operand |
| idx | input | 32 | Second pointer used as index |
| disp | input | 32 | Displacement or immediate operand |
| base | input | 32 | Circular buffer start |
| modv | input | 32 | Buffer length or wrap mask |
| out_valid | output | 1 | Results valid |
| ea | output | 32 | Effective address |
| next_ptr | output | 32 | Updated pointer value |

## Verification
Some properties are checked on every cycle: the one-cycle valid timing, push and pop arithmetic, and that address-only codes and unused codes leave the pointer alone. Pointers 8 to 15 must step linearly. A circular increment that starts inside the buffer must stay inside it, and the power-of-two mode must keep the bits above the mask. The exact wrapped values can only be shown by the bench's scenarios: the circular wrap points in both directions, the reverse-carry sequence and several wraps within one update. The bench checks these, together with a long random mix, against its own behavioural model.

// File: rtl/addr_mod_unit.sv
module addr_mod_unit #(
  parameter int AW      = 32,
  parameter int NPTR    = 16,
  parameter int NMODE   = 8,
  parameter int SP_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [3:0]           op,
  input  logic [$clog2(NPTR)-1:0] ptr_sel,
  input  logic [2*NMODE-1:0]   mode_ctl,
  input  logic [1:0]           width,
  input  logic [AW-1:0]        ptr,
  input  logic [AW-1:0]        ofs,
  input  logic [AW-1:0]        idx,
  input  logic [AW-1:0]        disp,
  input  logic [AW-1:0]        base,
  input  logic [AW-1:0]        modv,
  output logic                 out_valid,
  output logic [AW-1:0]        ea,
  output logic [AW-1:0]        next_ptr
);
  localparam int SELW = $clog2(NPTR);
  localparam logic [AW-1:0] SPD = AW'(SP_STEP);

  localparam logic [3:0] OP_INC = 4'd0, OP_DEC = 4'd1, OP_ADD = 4'd2,
                         OP_IXO = 4'd3, OP_IXP = 4'd4, OP_DSS = 4'd5,
                         OP_DSW = 4'd6, OP_IMM = 4'd7, OP_PSH = 4'd8,
                         OP_POP = 4'd9;

  localparam logic [1:0] M_LIN = 2'b00, M_MOD = 2'b01, M_MWR = 2'b10;

  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic [1:0]    mode;
  logic [AW-1:0] step, ofs_s, idx_s, dsp_s;
  logic [AW-1:0] mag, delta, lin, circ, mwr, rcar, upd;
  logic          neg;
  logic [AW-1:0] ea_c, nx_c;

  always_comb begin
    mode = M_LIN;
    for (int i = 0; i < NMODE; i++)
      if (ptr_sel == SELW'(i)) mode = mode_ctl[2*i +: 2];
  end

  assign step  = AW'(1) << width;
  assign ofs_s = ofs << width;
  assign idx_s = idx << width;
  assign dsp_s = disp << width;

  always_comb begin
    neg = 1'b0;
    mag = step;
    case (op)
      OP_DEC: neg = 1'b1;
      OP_ADD: begin
        neg = ofs_s[AW-1];
        mag = neg ? -ofs_s : ofs_s;
      end
      OP_IMM: begin
        neg = disp[AW-1];
        mag = neg ? -disp : disp;
      end
      default: ;
    endcase
  end

  assign delta = neg ? -mag : mag;
  assign lin   = ptr + delta;

  assign circ = neg ? ((lin < base) ? lin + modv : lin)
                    : ((lin >= base + modv) ? lin - modv : lin);

  assign mwr  = (ptr & ~modv) | (lin & modv);

  assign rcar = neg ? rev(rev(ptr) - rev(mag)) : rev(rev(ptr) + rev(mag));

  always_comb begin
    case (mode)
      M_LIN:   upd = lin;
      M_MOD:   upd = circ;
      M_MWR:   upd = mwr;
      default: upd = rcar;
    endcase
  end

  always_comb begin
    ea_c = ptr;
    nx_c = ptr;
    case (op)
      OP_INC, OP_DEC, OP_ADD, OP_IMM: nx_c = upd;
      OP_IXO: ea_c = ptr + ofs_s;
      OP_IXP: ea_c = ptr + idx_s;
      OP_DSS: ea_c = ptr + dsp_s;
      OP_DSW: ea_c = ptr + disp;
      OP_PSH: nx_c = ptr + SPD;
      OP_POP: begin
        ea_c = ptr - SPD;
        nx_c = ptr - SPD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ea        <= '0;
      next_ptr  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        ea       <= ea_c;
        next_ptr <= nx_c;
      end
    end
  end
endmodule

module addr_mod_unit_chk #(
  parameter int AW    = 32,
  parameter int NPTR  = 16,
  parameter int NMODE = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic [3:0]              op,
  input logic [$clog2(NPTR)-1:0] ptr_sel,
  input logic [2*NMODE-1:0]      mode_ctl,
  input logic [1:0]              width,
  input logic [AW-1:0]           ptr,
  input logic [AW-1:0]           base,
  input logic [AW-1:0]           modv,
  input logic                    out_valid,
  input logic [AW-1:0]           ea,
  input logic [AW-1:0]           next_ptr
);
  localparam int SELW = $clog2(NPTR);
  logic [1:0] cmode;
  logic       hi_ptr, mod_op;

  always_comb begin
    cmode = 2'b00;
    for (int i = 0; i < NMODE; i++)
      if (ptr_sel == SELW'(i)) cmode = mode_ctl[2*i +: 2];
  end
  assign hi_ptr = 32'(ptr_sel) >= NMODE;
  assign mod_op = (op == 4'd0) || (op == 4'd1) || (op == 4'd2) || (op == 4'd7);

  a_r10_valid_hi: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  a_r10_valid_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && $stable(ea) && $stable(next_ptr));
  a_r8_push: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 4'd8 |=> ea == $past(ptr) && next_ptr == $past(ptr) + AW'(8));
  a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op == 4'd9 |=> ea == $past(ptr) - AW'(8) && next_ptr == $past(ptr) - AW'(8));
  a_r3_ptr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op >= 4'd3 && op <= 4'd6 |=> next_ptr == $past(ptr));
  a_r11_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && op >= 4'd10 |=> ea == $past(ptr) && next_ptr == $past(ptr));
  a_r9_high_linear: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && hi_ptr && op == 4'd0 |=> next_ptr == $past(ptr) + (AW'(1) << $past(width)));
  a_r5_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hi_ptr && cmode == 2'b01 && op == 4'd0 && ptr >= base &&
    ptr < base + modv && (AW'(1) << width) <= modv
    |=> next_ptr >= $past(base) && next_ptr < $past(base) + $past(modv));
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hi_ptr && cmode == 2'b10 && mod_op
    |=> (next_ptr & ~$past(modv)) == ($past(ptr) & ~$past(modv)));
endmodule

bind addr_mod_unit addr_mod_unit_chk #(.AW(AW), .NPTR(NPTR), .NMODE(NMODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .ptr_sel(ptr_sel),
  .mode_ctl(mode_ctl), .width(width), .ptr(ptr), .base(base), .modv(modv),
  .out_valid(out_valid), .ea(ea), .next_ptr(next_ptr)
);

// File: tb/addr_mod_unit_tb.sv
module addr_mod_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [3:0]  ptr_sel = '0;
  logic [15:0] mode_ctl = '0;
  logic [1:0]  width = '0;
  logic [31:0] ptr = '0, ofs = '0, idx = '0, disp = '0, base = '0, modv = '0;
  logic        out_valid;
  logic [31:0] ea, next_ptr;

  int checks = 0, fails = 0;
  logic [31:0] last_next;
  logic [31:0] hold_ea, hold_nx;

  always #10 clk = ~clk;

  addr_mod_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .ptr_sel(ptr_sel),
    .mode_ctl(mode_ctl), .width(width), .ptr(ptr), .ofs(ofs), .idx(idx),
    .disp(disp), .base(base), .modv(modv), .out_valid(out_valid), .ea(ea),
    .next_ptr(next_ptr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rc_step(input logic [31:0] a, input logic [31:0] b, input bit sub);
    logic [31:0] r = '0;
    int c = 0;
    for (int i = 31; i >= 0; i--) begin
      int s;
      if (sub) begin
        s = int'(a[i]) - int'(b[i]) - c;
        c = (s < 0) ? 1 : 0;
      end else begin
        s = int'(a[i]) + int'(b[i]) + c;
        c = (s > 1) ? 1 : 0;
      end
      r[i] = s[0];
    end
    return r;
  endfunction

  task automatic model(input logic [3:0] o, input logic [3:0] sel, input logic [1:0] w,
                       input logic [31:0] p, input logic [31:0] f, input logic [31:0] x,
                       input logic [31:0] d, output logic [31:0] e, output logic [31:0] n);
    longint dl, s, m, low, nl;
    int md;
    logic [31:0] sc;
    md = (sel >= 8) ? 0 : int'(mode_ctl[2*sel +: 2]);
    e = p;
    n = p;
    case (o)
      4'd3: e = p + (f << w);
      4'd4: e = p + (x << w);
      4'd5: e = p + (d << w);
      4'd6: e = p + d;
      4'd8: n = p + 32'd8;
      4'd9: begin e = p - 32'd8; n = p - 32'd8; end
      default: ;
    endcase
    if (o == 4'd0 || o == 4'd1 || o == 4'd2 || o == 4'd7) begin
      case (o)
        4'd0: dl = longint'(1) << w;
        4'd1: dl = -(longint'(1) << w);
        4'd2: begin sc = f << w; dl = longint'($signed(sc)); end
        default: dl = longint'($signed(d));
      endcase
      if (md == 0) n = p + 32'(dl);
      else if (md == 1) begin
        s = longint'(p) + dl;
        if (dl >= 0 && s >= longint'(base) + longint'(modv)) s -= longint'(modv);
        if (dl < 0 && s < longint'(base)) s += longint'(modv);
        n = 32'(s);
      end else if (md == 2) begin
        m = longint'(modv) + 1;
        low = longint'(p) % m;
        nl = ((low + dl) % m + m) % m;
        n = 32'(longint'(p) - low + nl);
      end else begin
        if (dl < 0) n = rc_step(p, 32'(-dl), 1'b1);
        else        n = rc_step(p, 32'(dl), 1'b0);
      end
    end
  endtask

  task automatic apply(input string req, input logic [3:0] o, input logic [3:0] sel,
                       input logic [1:0] w, input logic [31:0] p, input logic [31:0] f,
                       input logic [31:0] x, input logic [31:0] d);
    logic [31:0] e, n;
    model(o, sel, w, p, f, x, d, e, n);
    req_valid = 1'b1; op = o; ptr_sel = sel; width = w;
    ptr = p; ofs = f; idx = x; disp = d;
    @(negedge clk);
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " ea"}, ea, e);
    chk({req, " next"}, next_ptr, n);
    last_next = next_ptr;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R10 reset ea", ea, 32'd0);
    chk("R10 reset next", next_ptr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 linear steps by width
    mode_ctl = 16'h0000;
    for (int w = 0; w < 4; w++) apply("R1 inc", 4'd0, 4'd0, 2'(w), 32'h100, 0, 0, 0);
    apply("R1 dec", 4'd1, 4'd0, 2'd2, 32'h100, 0, 0, 0);
    apply("R1 dec dword", 4'd1, 4'd1, 2'd3, 32'h100, 0, 0, 0);

    // R2 post-add scaled offset and unscaled immediate
    apply("R2 add ofs", 4'd2, 4'd0, 2'd1, 32'h2000, 32'h10, 0, 0);
    apply("R2 add neg ofs", 4'd2, 4'd0, 2'd3, 32'h2000, 32'hFFFF_FFFE, 0, 0);
    apply("R2 imm", 4'd7, 4'd0, 2'd3, 32'h2000, 0, 0, 32'h12);

    // R3 effective address forms
    apply("R3 idx ofs", 4'd3, 4'd0, 2'd2, 32'h4000, 32'h3, 0, 0);
    apply("R3 idx ptr", 4'd4, 4'd0, 2'd3, 32'h4000, 0, 32'h5, 0);
    apply("R3 disp short", 4'd5, 4'd0, 2'd1, 32'h4000, 0, 0, 32'h7);
    apply("R3 disp word", 4'd6, 4'd0, 2'd3, 32'h4000, 0, 0, 32'h7);

    // R4 reverse-carry, pointer 4
    mode_ctl = 16'h0300;
    apply("R4 rc1", 4'd2, 4'd4, 2'd2, 32'hC00, 32'h200, 0, 0);
    chk("R4 seq1", last_next, 32'h200);
    apply("R4 rc2", 4'd2, 4'd4, 2'd2, last_next, 32'h200, 0, 0);
    chk("R4 seq2", last_next, 32'hA00);
    apply("R4 rc3", 4'd2, 4'd4, 2'd2, last_next, 32'h200, 0, 0);
    chk("R4 seq3", last_next, 32'h600);
    apply("R4 rc back", 4'd2, 4'd4, 2'd2, 32'h600, 32'hFFFF_FE00, 0, 0);
    chk("R4 inverse", last_next, 32'hA00);

    // R5 / R6 circular buffer, pointer 2
    mode_ctl = 16'h0010; base = 32'h1007; modv = 32'hA0;
    apply("R5 inc", 4'd0, 4'd2, 2'd0, 32'h10A5, 0, 0, 0);
    chk("R5 step", last_next, 32'h10A6);
    apply("R5 wrap", 4'd0, 4'd2, 2'd0, last_next, 0, 0, 0);
    chk("R5 wrapped", last_next, 32'h1007);
    apply("R5 imm wrap", 4'd7, 4'd2, 2'd0, 32'h10A6, 0, 0, 32'h1);
    chk("R5 imm wrapped", last_next, 32'h1007);
    apply("R6 dec wrap", 4'd1, 4'd2, 2'd0, 32'h1007, 0, 0, 0);
    chk("R6 wrapped", last_next, 32'h10A6);
    apply("R6 dec half", 4'd1, 4'd2, 2'd1, 32'h1008, 0, 0, 0);
    chk("R6 half wrapped", last_next, 32'h10A6);

    // R7 power-of-two wrap, pointer 2
    mode_ctl = 16'h0020; modv = 32'h7;
    apply("R7 mw1", 4'd2, 4'd2, 2'd1, 32'hABC4, 32'h11, 0, 0);
    chk("R7 seq1", last_next, 32'hABC6);
    apply("R7 mw2", 4'd2, 4'd2, 2'd1, last_next, 32'h11, 0, 0);
    chk("R7 seq2", last_next, 32'hABC0);
    apply("R7 mw imm", 4'd7, 4'd2, 2'd1, last_next, 0, 0, 32'h12);
    chk("R7 seq3", last_next, 32'hABC2);

    // R8 stack
    apply("R8 push", 4'd8, 4'd15, 2'd0, 32'h8000, 0, 0, 0);
    apply("R8 pop", 4'd9, 4'd15, 2'd3, 32'h8000, 0, 0, 0);

    // R9 high pointers always linear
    mode_ctl = 16'hFFFF; base = 32'h0; modv = 32'h3;
    apply("R9 high linear", 4'd0, 4'd10, 2'd2, 32'h5555, 0, 0, 0);
    chk("R9 high value", last_next, 32'h5559);

    // R11 unused code
    apply("R11 unused", 4'd13, 4'd0, 2'd2, 32'h1234, 32'h10, 32'h20, 32'h30);

    // R10 hold while idle
    hold_ea = ea; hold_nx = next_ptr;
    ptr = 32'hDEAD; op = 4'd0;
    @(negedge clk);
    chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R10 idle ea", ea, hold_ea);
    chk("R10 idle next", next_ptr, hold_nx);

    // Random mix over linear, power-of-two wrap and reverse-carry modes
    base = 32'h0;
    for (int k = 0; k < 300; k++) begin
      logic [3:0] o, s;
      logic [1:0] wr;
      int r;
      r = int'($urandom_range(0, 2));
      mode_ctl = {8{(r == 0) ? 2'b00 : (r == 1) ? 2'b10 : 2'b11}};
      modv = (32'd1 << $urandom_range(1, 8)) - 32'd1;
      o = 4'($urandom_range(0, 15));
      s = 4'($urandom_range(0, 15));
      wr = 2'($urandom_range(0, 3));
      apply("R1 R2 R3 R4 R7 R8 R9 random", o, s, wr, $urandom, $urandom_range(0, 255),
            $urandom, $urandom_range(0, 255) - 128);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule